// File: doc/BRIEF.md
# Uncached Store Gathering Buffer

This block sits between a processor's load/store pipeline and a bus that serves uncached storage. It holds at most one pending entry covering one naturally aligned 16-byte line. Separate load requests, or separate store requests, whose byte enables do not overlap are combined into that entry. The entry then leaves as a single bus read or bus write. The entry is released as soon as the bus has answered, and no uncached byte is kept after that.

Ordering is controlled by two barrier inputs. A full barrier always drains the buffer before it is acknowledged. A lighter I/O-ordering barrier drains it only when the pending entry maps guarded storage. For unguarded storage it is acknowledged at once, and later requests keep merging into the same entry. An idle timer issues an entry that has not grown for a programmable number of cycles.

Requests use a valid/ready handshake. The requester holds `req_valid` and the payload until it sees `req_ready` high at a clock edge. `req_ready` may depend on the payload offered, and it is low whenever a barrier is being presented. The barrier is a valid/ack handshake. The requester holds `bar_valid` until `bar_ack` is high at an edge, and it offers no request while doing so. The bus channel is also valid/ready. The buffer holds `bus_valid` and the payload until `bus_ready`. It then waits for `rsp_valid` before it starts anything else.

Top module: `ucg_gather_buf`

## Requirements
- R1: After reset, with no inputs active, `req_ready` is 1 and `bus_valid`, `bar_ack` and `ld_valid` are 0.
- R2: Stores to the same line (address bits above bit 3) with non-zero, mutually disjoint byte enables and the same guarded bit leave as one bus write. In that write, `bus_load`=0, `bus_addr` is the line base with bits 3:0 zero, and `bus_be` is the OR of the enables. Each enabled byte lane of `bus_wdata` carries the data of the request that enabled it, and lanes that are not enabled are zero.
- R3: Loads that meet the same conditions leave as one bus read with `bus_load`=1 and the merged enables. When `rsp_valid` arrives, `ld_valid` is high for that cycle, with `ld_data`=`rsp_rdata` and `ld_be` set to the merged enables.
- R4: A request to another line, or one that overlaps pending bytes, or one of the other direction, or one with a different guarded bit, is not merged. `req_ready` stays low until the pending entry has been issued and answered. The request then starts a new entry, and bus accesses appear in request order.
- R5: A full barrier (`bar_full`=1) flushes a pending entry. It is acknowledged only when no entry is pending and no bus access is outstanding. Requests after it are never merged with requests before it.
- R6: An I/O barrier (`bar_full`=0) behaves as a full barrier when the pending entry is guarded. When the pending entry is unguarded, the I/O barrier is acknowledged with the entry still pending, and later requests merge into it.
- R7: While `bar_valid` is high, `req_ready` is 0.
- R8: With no further request accepted, `bus_valid` rises `idle_limit` clock edges after the edge that accepted the last request. An `idle_limit` of 0 acts as 1.
- R9: `bus_valid` stays high with stable `bus_addr`, `bus_be` and `bus_wdata` until `bus_ready`. After a handshake, `bus_valid` stays low until `rsp_valid` has been seen, so at most one access is outstanding.
- R10: `bus_be` is never wider than the union of the accepted enables, for guarded and unguarded storage alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | 4 | Idle cycles before a pending entry is issued (0 acts as 1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at this edge |
| req_load | input | 1 | 1 = load, 0 = store |
| req_addr | input | 32 | Byte address; only the line part is used |
| req_be | input | 16 | Byte enables within the line, non-zero |
| req_wdata | input | 128 | Store data, lane-aligned |
| req_guarded | input | 1 | Target storage is guarded |
| bar_valid | input | 1 | Barrier presented |
| bar_full | input | 1 | 1 = full barrier, 0 = I/O-ordering barrier |
| bar_ack | output | 1 | Barrier completes at this edge |
| bus_valid | output | 1 | Bus access offered |
| bus_ready | input | 1 | Bus accepts the access |
| bus_load | output | 1 | 1 = read, 0 = write |
| bus_addr | output | 32 | Line base address |
| bus_be | output | 16 | Byte enables of the access |
| bus_wdata | output | 128 | Write data |
| rsp_valid | input | 1 | Bus response for the outstanding access |
| rsp_rdata | input | 128 | Read data of the response |
| ld_valid | output | 1 | Merged load data returned |
| ld_be | output | 16 | Bytes requested by the merged loads |
| ld_data | output | 128 | Read data for the merged loads |

## Verification
A corrupted entry register shows up on the bus within one transaction. It appears as merged enables that do not add up, a lane carrying another request's byte, or a write landing on the wrong line base. A state machine stuck in the wrong phase shows up within a few cycles. It appears as a second `bus_valid` before the response, a barrier acknowledged while an access is still in flight, or an idle issue that arrives one cycle early or late against `idle_limit`. The directed scenarios cover each merge-blocking cause and both barrier kinds on both kinds of storage. They compare the exact bus sequence and the cycle of each event against values derived from the requirements.

// File: rtl/ucg_pkg.sv
package ucg_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_PEND  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } ucg_state_e;
endpackage

// File: rtl/ucg_merge_chk.sv
module ucg_merge_chk #(
  parameter int LW = 28,
  parameter int LB = 16
) (
  input  logic          pend_valid,
  input  logic [LW-1:0] pend_line,
  input  logic [LB-1:0] pend_be,
  input  logic          pend_load,
  input  logic          pend_guarded,
  input  logic [LW-1:0] req_line,
  input  logic [LB-1:0] req_be,
  input  logic          req_load,
  input  logic          req_guarded,
  output logic          can_merge
);
  logic same_line, disjoint, same_dir, same_attr;

  always_comb begin
    same_line = (pend_line == req_line);
    disjoint  = ((pend_be & req_be) == '0);
    same_dir  = (pend_load == req_load);
    same_attr = (pend_guarded == req_guarded);
    can_merge = pend_valid && same_line && disjoint && same_dir && same_attr;
  end
endmodule

// File: rtl/ucg_idle_timer.sv
module ucg_idle_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_eff;

  always_comb begin
    lim_eff = (limit == '0) ? TW'(1) : limit;
    expire  = run && !restart && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_eff});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run || expire) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim_eff)); // R8
endmodule

// File: rtl/ucg_barrier_ctl.sv
module ucg_barrier_ctl
  import ucg_pkg::*;
(
  input  logic       bar_valid,
  input  logic       bar_full,
  input  ucg_state_e st,
  input  logic       pend_guarded,
  output logic       bar_ack,
  output logic       bar_flush
);
  logic must_drain;

  always_comb begin
    must_drain = bar_full || pend_guarded;
    bar_ack    = bar_valid && ((st == ST_EMPTY) || (!must_drain && st == ST_PEND));
    bar_flush  = bar_valid && must_drain && (st == ST_PEND);
  end
endmodule

// File: rtl/ucg_gather_buf.sv
module ucg_gather_buf
  import ucg_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int TW         = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TW-1:0]           idle_limit,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_load,
  input  logic [AW-1:0]           req_addr,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  input  logic                    req_guarded,
  input  logic                    bar_valid,
  input  logic                    bar_full,
  output logic                    bar_ack,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic                    bus_load,
  output logic [AW-1:0]           bus_addr,
  output logic [LINE_BYTES-1:0]   bus_be,
  output logic [LINE_BYTES*8-1:0] bus_wdata,
  input  logic                    rsp_valid,
  input  logic [LINE_BYTES*8-1:0] rsp_rdata,
  output logic                    ld_valid,
  output logic [LINE_BYTES-1:0]   ld_be,
  output logic [LINE_BYTES*8-1:0] ld_data
);
  localparam int LB  = LINE_BYTES;
  localparam int DW  = LB * 8;
  localparam int OFS = $clog2(LB);
  localparam int LW  = AW - OFS;

  ucg_state_e    st_q, st_d;
  logic [LW-1:0] line_q;
  logic [LB-1:0] be_q, be_d;
  logic [DW-1:0] data_q, data_d;
  logic          load_q, guarded_q;

  logic [LW-1:0] req_line;
  logic          addr_ofs_unused;
  logic          can_merge, accept, expire, bar_flush, clr, start;

  assign req_line        = req_addr[AW-1:OFS];
  assign addr_ofs_unused = ^req_addr[OFS-1:0];

  ucg_merge_chk #(.LW(LW), .LB(LB)) u_merge (
    .pend_valid  (st_q == ST_PEND),
    .pend_line   (line_q),
    .pend_be     (be_q),
    .pend_load   (load_q),
    .pend_guarded(guarded_q),
    .req_line    (req_line),
    .req_be      (req_be),
    .req_load    (req_load),
    .req_guarded (req_guarded),
    .can_merge   (can_merge)
  );

  ucg_idle_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st_q == ST_PEND),
    .restart(accept),
    .limit  (idle_limit),
    .expire (expire)
  );

  ucg_barrier_ctl u_bar (
    .bar_valid   (bar_valid),
    .bar_full    (bar_full),
    .st          (st_q),
    .pend_guarded(guarded_q),
    .bar_ack     (bar_ack),
    .bar_flush   (bar_flush)
  );

  always_comb begin
    req_ready = !bar_valid && ((st_q == ST_EMPTY) || can_merge);
    accept    = req_valid && req_ready;
    start     = accept && (st_q == ST_EMPTY);
    clr       = (st_q == ST_WAIT) && rsp_valid;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_EMPTY: if (accept) st_d = ST_PEND;
      ST_PEND: begin
        if (!accept && ((req_valid && !can_merge) || bar_flush || expire))
          st_d = ST_ISSUE;
      end
      ST_ISSUE: if (bus_ready) st_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) st_d = ST_EMPTY;
      default:  st_d = ST_EMPTY;
    endcase
  end

  always_comb begin
    if (clr)         be_d = '0;
    else if (start)  be_d = req_be;
    else if (accept) be_d = be_q | req_be;
    else             be_d = be_q;
  end

  for (genvar i = 0; i < LB; i++) begin : g_lane
    assign data_d[i*8 +: 8] =
      clr                  ? 8'h00 :
      (accept && req_be[i]) ? req_wdata[i*8 +: 8] :
      start                ? 8'h00 :
                             data_q[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_EMPTY;
      be_q      <= '0;
      data_q    <= '0;
      line_q    <= '0;
      load_q    <= 1'b0;
      guarded_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      be_q   <= be_d;
      data_q <= data_d;
      if (start) begin
        line_q    <= req_line;
        load_q    <= req_load;
        guarded_q <= req_guarded;
      end
    end
  end

  always_comb begin
    bus_valid = (st_q == ST_ISSUE);
    bus_load  = load_q;
    bus_addr  = {line_q, {OFS{1'b0}}};
    bus_be    = be_q;
    bus_wdata = data_q;
    ld_valid  = clr && load_q;
    ld_be     = be_q;
    ld_data   = rsp_rdata;
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_wdata))); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> !bus_valid); // R9
  AST_MERGE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st_q == ST_PEND) |=>
      ($countones(be_q) == $past($countones(be_q)) + $past($countones(req_be)))); // R2
  AST_FULL_BAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_ack && bar_full) |-> (st_q == ST_EMPTY)); // R5
  AST_FULL_BAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && bar_full && st_q == ST_PEND) |=> (st_q == ST_ISSUE)); // R5
  AST_BAR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && st_q == ST_PEND) |=> (be_q == $past(be_q) || st_q != ST_PEND)); // R7
  AST_BE_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_be != '0)); // R10
endmodule

// File: tb/tb_ucg_gather_buf.sv
module tb_ucg_gather_buf;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int DW = 128;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [TW-1:0] idle_limit;
  logic req_valid, req_ready, req_load, req_guarded;
  logic [AW-1:0] req_addr;
  logic [LB-1:0] req_be;
  logic [DW-1:0] req_wdata;
  logic bar_valid, bar_full, bar_ack;
  logic bus_valid, bus_ready, bus_load;
  logic [AW-1:0] bus_addr;
  logic [LB-1:0] bus_be;
  logic [DW-1:0] bus_wdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic ld_valid;
  logic [LB-1:0] ld_be;
  logic [DW-1:0] ld_data;

  ucg_gather_buf #(.AW(AW), .LINE_BYTES(LB), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_load(req_load),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_guarded(req_guarded), .bar_valid(bar_valid), .bar_full(bar_full),
    .bar_ack(bar_ack), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_load(bus_load), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ld_valid(ld_valid), .ld_be(ld_be), .ld_data(ld_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus log
  logic          bl_load [64];
  logic [31:0]   bl_addr [64];
  logic [15:0]   bl_be   [64];
  logic [127:0]  bl_data [64];
  int n_bus = 0;
  logic [15:0]   ll_be   [16];
  logic [127:0]  ll_data [16];
  int n_ld = 0;
  int stall_left = 0;
  int vcyc = 0;
  int stab_err = 0;
  int rise_cyc = -1;
  int out_viol = 0;
  bit outst = 0;
  int rsp_delay = 0;
  logic [31:0] out_addr = '0;
  bit prev_bv = 0;
  bit prev_hold = 0;
  logic [AW-1:0] h_addr;
  logic [LB-1:0] h_be;
  logic [DW-1:0] h_data;

  function automatic logic [127:0] mkdata(input logic [31:0] s);
    return {s ^ 32'hA5A5_0101, s ^ 32'h5A5A_0202, s ^ 32'h3C3C_0303, s ^ 32'hC3C3_0404};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder and monitor
  always begin
    @(negedge clk);
    rsp_valid = 1'b0;
    if (outst) begin
      if (rsp_delay == 0) begin
        rsp_valid = 1'b1;
        rsp_rdata = mkdata(out_addr);
        outst = 0;
      end else rsp_delay--;
    end
    bus_ready = (stall_left == 0);
    if (stall_left > 0 && bus_valid) stall_left--;
    #4;
    if (bus_valid) begin
      vcyc++;
      if (outst) out_viol++;
      if (prev_hold && (bus_addr !== h_addr || bus_be !== h_be || bus_wdata !== h_data))
        stab_err++;
    end
    if (bus_valid && !prev_bv) rise_cyc = cyc;
    prev_bv = bus_valid;
    prev_hold = bus_valid && !bus_ready;
    h_addr = bus_addr; h_be = bus_be; h_data = bus_wdata;
    if (bus_valid && bus_ready) begin
      if (n_bus < 64) begin
        bl_load[n_bus] = bus_load; bl_addr[n_bus] = bus_addr;
        bl_be[n_bus] = bus_be; bl_data[n_bus] = bus_wdata;
      end
      n_bus++;
      outst = 1; rsp_delay = 1; out_addr = bus_addr;
    end
    if (ld_valid) begin
      if (n_ld < 16) begin ll_be[n_ld] = ld_be; ll_data[n_ld] = ld_data; end
      n_ld++;
    end
  end

  // called at a falling edge, returns at the falling edge after acceptance
  task automatic send_req(input bit ld, input logic [31:0] addr, input logic [15:0] be,
                          input logic [127:0] d, input bit g);
    bit ok;
    req_valid = 1'b1; req_load = ld; req_addr = addr; req_be = be;
    req_wdata = d; req_guarded = g;
    forever begin
      #4; ok = req_ready;
      @(negedge clk);
      if (ok) break;
    end
    req_valid = 1'b0;
  endtask

  int bar_req_viol = 0;
  task automatic send_bar(input bit full);
    bit ok;
    bar_valid = 1'b1; bar_full = full;
    forever begin
      #4; ok = bar_ack;
      if (req_ready) bar_req_viol++;
      @(negedge clk);
      if (ok) break;
    end
    bar_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    #4;
    chk(req_ready === 1'b1, "R1 req_ready after reset", 128'(req_ready), 128'd1);
    chk(bus_valid === 1'b0, "R1 bus_valid after reset", 128'(bus_valid), 128'd0);
    chk(bar_ack === 1'b0 && ld_valid === 1'b0, "R1 bar_ack/ld_valid after reset",
        128'({bar_ack, ld_valid}), 128'd0);
    @(negedge clk);
  endtask

  task automatic t_store_merge();
    int b0;
    logic [127:0] d1, d2, d3, exp;
    b0 = n_bus;
    d1 = mkdata(32'h11); d2 = mkdata(32'h22); d3 = mkdata(32'h33);
    send_req(0, 32'h0000_0100, 16'h000F, d1, 0);
    send_req(0, 32'h0000_0104, 16'h00F0, d2, 0);
    send_req(0, 32'h0000_010C, 16'hF000, d3, 0);
    wait_quiet();
    exp = '0;
    for (int b = 0; b < 16; b++) begin
      if (b < 4) exp[b*8 +: 8] = d1[b*8 +: 8];
      else if (b < 8) exp[b*8 +: 8] = d2[b*8 +: 8];
      else if (b >= 12) exp[b*8 +: 8] = d3[b*8 +: 8];
    end
    chk(n_bus == b0 + 1, "R2 one merged write", 128'(n_bus - b0), 128'd1);
    chk(bl_load[b0] == 0 && bl_addr[b0] == 32'h100, "R2 write addr/dir",
        128'({bl_load[b0], bl_addr[b0]}), 128'h100);
    chk(bl_be[b0] == 16'hF0FF, "R10 merged enables exact", 128'(bl_be[b0]), 128'hF0FF);
    chk(bl_data[b0] == exp, "R2 merged lanes", bl_data[b0], exp);
  endtask

  task automatic t_load_merge();
    int b0, l0;
    b0 = n_bus; l0 = n_ld;
    send_req(1, 32'h0000_0200, 16'h0003, '0, 0);
    send_req(1, 32'h0000_0208, 16'h0300, '0, 0);
    wait_quiet();
    chk(n_bus == b0 + 1 && bl_load[b0] == 1, "R3 one merged read",
        128'(n_bus - b0), 128'd1);
    chk(bl_be[b0] == 16'h0303 && bl_addr[b0] == 32'h200, "R3 read enables/addr",
        128'({bl_addr[b0], bl_be[b0]}), 128'h200_0303);
    chk(n_ld == l0 + 1 && ll_be[l0] == 16'h0303, "R3 load return enables",
        128'(ll_be[l0]), 128'h0303);
    chk(ll_data[l0] == mkdata(32'h200), "R3 load return data", ll_data[l0], mkdata(32'h200));
  endtask

  task automatic t_split();
    int b0;
    logic [127:0] d2;
    // overlap
    b0 = n_bus; d2 = mkdata(32'h77);
    send_req(0, 32'h0000_0300, 16'h000F, mkdata(32'h66), 0);
    send_req(0, 32'h0000_0300, 16'h0001, d2, 0);
    wait_quiet();
    chk(n_bus == b0 + 2 && bl_be[b0] == 16'h000F && bl_be[b0+1] == 16'h0001,
        "R4 overlap splits in order", 128'({bl_be[b0], bl_be[b0+1]}), 128'h000F_0001);
    chk(bl_data[b0+1] == {120'd0, d2[7:0]}, "R4 second write data",
        bl_data[b0+1], {120'd0, d2[7:0]});
    // direction
    b0 = n_bus;
    send_req(0, 32'h0000_0400, 16'h0001, mkdata(32'h1), 0);
    send_req(1, 32'h0000_0400, 16'h0002, '0, 0);
    wait_quiet();
    chk(n_bus == b0 + 2 && bl_load[b0] == 0 && bl_load[b0+1] == 1,
        "R4 store then load not merged", 128'({bl_load[b0], bl_load[b0+1]}), 128'b01);
    // other line
    b0 = n_bus;
    send_req(0, 32'h0000_0A00, 16'h0001, mkdata(32'h2), 0);
    send_req(0, 32'h0000_0A10, 16'h0002, mkdata(32'h3), 0);
    wait_quiet();
    chk(n_bus == b0 + 2 && bl_addr[b0] == 32'hA00 && bl_addr[b0+1] == 32'hA10,
        "R4 other line splits", 128'({bl_addr[b0], bl_addr[b0+1]}), 128'h0A00_0000_0A10);
    // guarded mismatch
    b0 = n_bus;
    send_req(0, 32'h0000_0B00, 16'h0001, mkdata(32'h4), 0);
    send_req(0, 32'h0000_0B00, 16'h0002, mkdata(32'h5), 1);
    wait_quiet();
    chk(n_bus == b0 + 2, "R4 guarded mismatch splits", 128'(n_bus - b0), 128'd2);
  endtask

  task automatic t_timeout(input logic [3:0] lim, input int exp);
    int c0;
    idle_limit = lim;
    rise_cyc = -1;
    send_req(0, 32'h0000_0C00, 16'h0010, mkdata(32'h9), 0);
    c0 = cyc;
    wait_quiet();
    chk(rise_cyc - c0 == exp, "R8 idle issue delay", 128'(rise_cyc - c0), 128'(exp));
    idle_limit = 4'd15;
  endtask

  task automatic t_full_bar();
    int b0;
    b0 = n_bus; bar_req_viol = 0;
    send_req(0, 32'h0000_0500, 16'h0001, mkdata(32'h50), 0);
    send_bar(1);
    chk(n_bus == b0 + 1 && !outst, "R5 full barrier acked after drain",
        128'(n_bus - b0), 128'd1);
    chk(bar_req_viol == 0, "R7 req_ready low during barrier", 128'(bar_req_viol), 128'd0);
    send_req(0, 32'h0000_0500, 16'h0002, mkdata(32'h51), 0);
    wait_quiet();
    chk(n_bus == b0 + 2 && bl_be[b0+1] == 16'h0002, "R5 no merge across full barrier",
        128'(bl_be[b0+1]), 128'h0002);
  endtask

  task automatic t_io_bar_unguarded();
    int b0;
    b0 = n_bus; bar_req_viol = 0;
    send_req(0, 32'h0000_0600, 16'h0001, mkdata(32'h60), 0);
    send_bar(0);
    chk(n_bus == b0, "R6 io barrier unguarded acked without issue", 128'(n_bus - b0), 128'd0);
    send_req(0, 32'h0000_0600, 16'h0002, mkdata(32'h61), 0);
    wait_quiet();
    chk(n_bus == b0 + 1 && bl_be[b0] == 16'h0003, "R6 merge across io barrier",
        128'(bl_be[b0]), 128'h0003);
    chk(bar_req_viol == 0, "R7 req_ready low during io barrier", 128'(bar_req_viol), 128'd0);
  endtask

  task automatic t_io_bar_guarded();
    int b0;
    b0 = n_bus;
    send_req(0, 32'h0000_0700, 16'h0001, mkdata(32'h70), 1);
    send_bar(0);
    chk(n_bus == b0 + 1 && !outst, "R6 io barrier guarded drains", 128'(n_bus - b0), 128'd1);
    send_req(0, 32'h0000_0700, 16'h0002, mkdata(32'h71), 1);
    wait_quiet();
    chk(n_bus == b0 + 2 && bl_be[b0] == 16'h0001 && bl_be[b0+1] == 16'h0002,
        "R6 guarded no merge across io barrier", 128'({bl_be[b0], bl_be[b0+1]}),
        128'h0001_0002);
  endtask

  task automatic t_stall();
    int b0;
    logic [127:0] d, exp;
    b0 = n_bus; d = mkdata(32'h80);
    stall_left = 3; vcyc = 0; stab_err = 0; out_viol = 0;
    idle_limit = 4'd1;
    send_req(0, 32'h0000_0800, 16'hFF00, d, 1);
    wait_quiet();
    exp = {d[127:64], 64'd0};
    chk(vcyc == 4, "R9 bus_valid held through stall", 128'(vcyc), 128'd4);
    chk(stab_err == 0 && out_viol == 0, "R9 stable payload, one outstanding",
        128'({stab_err, out_viol}), 128'd0);
    chk(n_bus == b0 + 1 && bl_be[b0] == 16'hFF00 && bl_data[b0] == exp,
        "R10 guarded write enables not widened", bl_data[b0], exp);
    idle_limit = 4'd15;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_limit = 4'd15;
    req_valid = 0; req_load = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    req_guarded = 0; bar_valid = 0; bar_full = 0;
    bus_ready = 1; rsp_valid = 0; rsp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_merge();
    t_load_merge();
    t_split();
    t_timeout(4'd3, 3);
    t_timeout(4'd1, 1);
    t_timeout(4'd0, 1);
    t_full_bar();
    t_io_bar_unguarded();
    t_io_bar_guarded();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule